// File: doc/BRIEF.md
# Erase/Write Cycle Sequencer for a Serial EEPROM

This block runs the non-volatile programming cycle that follows a write transfer on a two-wire serial EEPROM. When the bus controller sees the STOP that closes a write, it pulses a start request together with the number of data bytes received, a page-mode flag, the first word address and the contents of the eight-byte data latch. The sequencer raises busy and steps through erase and write phases. At the end of every write phase it emits a one-cycle strobe carrying the target address and the data byte. It drops busy once the whole cycle has elapsed.

Two timebases are available. The internal one divides the system clock by a prescaler (PRE_DIV, 128 by default) into ticks, and a phase lasts INT_PH ticks (16 by default). The external one counts rising edges of a programming clock pin, and a phase lasts EXT_PH periods (128 by default). The bus controller pulses a selection event at the falling SCL edge that ends the eighth bit of the word address. At that moment the block samples a source-select pin: low selects the external clock, high selects the internal timebase. The choice holds until the next selection event that arrives while the block is idle.

In byte mode every byte gets its own erase phase and write phase. In page mode a single erase phase covers the whole page and the write phases follow one after another. One extra timebase unit ends every cycle, so a cycle lasts (phases × phase length + 1) units.

Top module: `prog_cycle_seq`

## Requirements
- R1: After synchronous reset, busy_o, erase_o and wr_stb_o are low.
- R2: A start_i pulse while idle sets busy_o and erase_o in the next cycle. The first phase is always an erase phase.
- R3: In external mode with byte mode and n bytes (1..8), busy_o falls after exactly n×256+1 rising edges of ext_clk_i. For n=1 that is 257 edges.
- R4: In external mode with page mode and n bytes, busy_o falls after (n+1)×128+1 rising edges of ext_clk_i. A full 8-byte page takes 1153 edges.
- R5: In internal mode, busy_o falls exactly (phases×INT_PH+1)×PRE_DIV clock cycles after the cycle in which start_i was accepted. phases is 2n in byte mode and n+1 in page mode.
- R6: Exactly one wr_stb_o pulse is issued per byte, at the end of that byte's write phase, in byte order. Byte k carries latch_i[8k+7:8k] on wr_data_o.
- R7: In byte mode, byte k goes to address addr_i + k, with the increment confined to the low 8 address bits: 0x2FF is followed by 0x200. The upper bits are kept.
- R8: In page mode, byte k goes to address addr_i + k, with the increment confined to the low 3 address bits: 0x15F is followed by 0x158.
- R9: A sel_evt_i pulse while idle selects external mode if src_pin_i is 0 and internal mode if it is 1. A sel_evt_i pulse while busy has no effect, neither on the running cycle nor on the next one.
- R10: A start_i pulse while busy is ignored. The running cycle's timing and strobes are unchanged, and no extra strobe appears.
- R11: Synchronous reset in the middle of a cycle drops busy_o in the next cycle, suppresses every pending strobe, and returns the block to internal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Pulse at the STOP that ends a write transfer |
| nbytes_i | input | CW | Number of data bytes, 1..8 |
| page_i | input | 1 | 1 = page mode, 0 = byte mode |
| addr_i | input | AW | First word address, including the page-select bits |
| latch_i | input | 8×NB | Data latch; byte k sits at bits 8k+7:8k |
| sel_evt_i | input | 1 | Pulse at the falling SCL edge after the eighth word-address bit |
| src_pin_i | input | 1 | Timebase select pin; low selects the external clock |
| ext_clk_i | input | 1 | External programming clock |
| busy_o | output | 1 | A programming cycle is in progress |
| erase_o | output | 1 | The current phase is an erase phase |
| wr_stb_o | output | 1 | One-cycle write strobe to the array |
| wr_addr_o | output | AW | Address for wr_stb_o |
| wr_data_o | output | 8 | Data for wr_stb_o |
| ext_mode_o | output | 1 | Latched timebase choice; 1 = external |

## Verification
Busy and the erase flag rise in the cycle after the accepted start, so the bench samples them at the first falling edge after that start. In internal mode busy falls on the edge numbered (phases×INT_PH+1)×PRE_DIV after the start edge. The bench counts every rising clock edge and checks busy on each falling edge, so the observed count must match that number exactly. In external mode the bench produces each programming-clock period itself and checks busy after each full period. The synchronizer delay of about three cycles then ends well inside the period, and the count of periods must equal the formula exactly. Strobes are compared in arrival order against a queue that was filled when the cycle started, and the bench confirms the queue is empty once busy falls.

// File: rtl/prog_cycle_seq.sv
module prog_cycle_seq #(
  parameter int AW      = 10,
  parameter int WB      = 8,
  parameter int PG_BITS = 3,
  parameter int PRE_DIV = 128,
  parameter int INT_PH  = 16,
  parameter int EXT_PH  = 128,
  localparam int NB     = 1 << PG_BITS,
  localparam int CW     = $clog2(NB + 1),
  localparam int PW     = $clog2(PRE_DIV),
  localparam int PH_MAX = (INT_PH > EXT_PH) ? INT_PH : EXT_PH,
  localparam int UW     = $clog2(PH_MAX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [CW-1:0]   nbytes_i,
  input  logic            page_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NB*8-1:0] latch_i,
  input  logic            sel_evt_i,
  input  logic            src_pin_i,
  input  logic            ext_clk_i,
  output logic            busy_o,
  output logic            erase_o,
  output logic            wr_stb_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [7:0]      wr_data_o,
  output logic            ext_mode_o
);

  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_WRITE, S_TAIL} st_t;

  st_t               st;
  logic [PW-1:0]     pre;
  logic [UW-1:0]     ucnt;
  logic [PG_BITS-1:0] idx;
  logic [CW-1:0]     n_lat;
  logic              page_lat;
  logic [AW-1:0]     addr_lat;
  logic [NB*8-1:0]   data_lat;
  logic [2:0]        xsync;

  assign busy_o  = (st != S_IDLE);
  assign erase_o = (st == S_ERASE);

  wire accept   = start_i & ~busy_o;
  wire tick_int = busy_o & (pre == PW'(PRE_DIV - 1));
  wire ext_rise = xsync[1] & ~xsync[2];
  wire unit     = ext_mode_o ? ext_rise : tick_int;
  wire [UW-1:0] ph_last = ext_mode_o ? UW'(EXT_PH - 1) : UW'(INT_PH - 1);
  wire in_phase = (st == S_ERASE) | (st == S_WRITE);
  wire ph_end   = unit & in_phase & (ucnt == ph_last);
  wire last_byt = ((CW'(idx) + CW'(1)) == n_lat);

  wire [AW-1:0] a_pg = {addr_lat[AW-1:PG_BITS], addr_lat[PG_BITS-1:0] + idx};
  wire [AW-1:0] a_by = {addr_lat[AW-1:WB], addr_lat[WB-1:0] + WB'(idx)};

  always_ff @(posedge clk) begin
    if (rst) xsync <= '0;
    else     xsync <= {xsync[1:0], ext_clk_i};
  end

  always_ff @(posedge clk) begin
    if (rst)
      ext_mode_o <= 1'b0;
    else if (sel_evt_i && !busy_o)
      ext_mode_o <= ~src_pin_i;
  end

  always_ff @(posedge clk) begin
    if (rst || accept || tick_int) pre <= '0;
    else if (busy_o)               pre <= pre + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ucnt     <= '0;
      idx      <= '0;
      n_lat    <= '0;
      page_lat <= 1'b0;
      addr_lat <= '0;
      data_lat <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_ERASE;
          ucnt     <= '0;
          idx      <= '0;
          n_lat    <= nbytes_i;
          page_lat <= page_i;
          addr_lat <= addr_i;
          data_lat <= latch_i;
        end
        S_ERASE, S_WRITE: if (unit) begin
          if (ph_end) begin
            ucnt <= '0;
            if (st == S_ERASE)
              st <= S_WRITE;
            else if (last_byt)
              st <= S_TAIL;
            else begin
              idx <= idx + PG_BITS'(1);
              st  <= page_lat ? S_WRITE : S_ERASE;
            end
          end else
            ucnt <= ucnt + UW'(1);
        end
        S_TAIL: if (unit) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= ph_end & (st == S_WRITE);
      if (ph_end && st == S_WRITE) begin
        wr_addr_o <= page_lat ? a_pg : a_by;
        wr_data_o <= data_lat[8*idx +: 8];
      end
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && erase_o)); // R2
  AST_STB_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> busy_o); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (CW'(idx) < n_lat)); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(ext_mode_o)); // R9
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(n_lat) && $stable(addr_lat))); // R10

endmodule

// File: tb/test_prog_cycle_seq.sv
module test_prog_cycle_seq;
  localparam int AW = 10, NB = 8, CW = 4, PRE = 4, IPH = 4;

  logic clk = 0, rst = 1;
  logic start_i = 0, page_i = 0, sel_evt_i = 0, src_pin_i = 1, ext_clk_i = 0;
  logic [CW-1:0] nbytes_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [NB*8-1:0] latch_i = '0;
  logic busy_o, erase_o, wr_stb_o, ext_mode_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0] wr_data_o;

  int errors = 0, checks = 0;
  logic [AW+7:0] exp_q[$];

  always #5 clk = ~clk;

  prog_cycle_seq #(.PRE_DIV(PRE), .INT_PH(IPH)) i_prog_cycle_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .nbytes_i(nbytes_i), .page_i(page_i),
    .addr_i(addr_i), .latch_i(latch_i), .sel_evt_i(sel_evt_i), .src_pin_i(src_pin_i),
    .ext_clk_i(ext_clk_i), .busy_o(busy_o), .erase_o(erase_o), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .ext_mode_o(ext_mode_o));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 59);
  endfunction

  always @(negedge clk) begin
    if (wr_stb_o) begin
      if (exp_q.size() == 0)
        chk(0, "R6 unexpected strobe", {wr_addr_o, wr_data_o}, 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        chk({wr_addr_o, wr_data_o} == e, "R6 R7 R8 strobe addr/data", {wr_addr_o, wr_data_o}, e);
      end
    end
  end

  task automatic select_src(input logic pin);
    @(negedge clk); src_pin_i = pin; sel_evt_i = 1;
    @(negedge clk); sel_evt_i = 0;
  endtask

  task automatic launch(input int n, input logic pg, input logic [AW-1:0] a, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ea;
      ea = pg ? {a[AW-1:3], 3'(a[2:0] + 3'(k))} : {a[AW-1:8], 8'(a[7:0] + 8'(k))};
      exp_q.push_back({ea, dbyte(seed, k)});
    end
    @(negedge clk);
    nbytes_i = CW'(n); page_i = pg; addr_i = a;
    for (int k = 0; k < NB; k++) latch_i[8*k +: 8] = dbyte(seed, k);
    start_i = 1;
    @(negedge clk); start_i = 0;
    chk(busy_o && erase_o, "R2 busy/erase after start", {busy_o, erase_o}, 2'b11);
  endtask

  // inject: 0 none, 1 start pulse mid-cycle, 2 selection pulse mid-cycle
  task automatic run_int(input int n, input logic pg, input logic [AW-1:0] a,
                         input logic [7:0] seed, input int inject);
    int cnt, ph, expc;
    ph = pg ? n + 1 : 2 * n;
    expc = 1 + (ph * IPH + 1) * PRE;
    launch(n, pg, a, seed);
    cnt = 1;
    while (cnt < 5000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (cnt == 6 && inject == 1) begin start_i = 1; nbytes_i = 4'd5; addr_i = 10'h011; end
      if (cnt == 6 && inject == 2) begin sel_evt_i = 1; src_pin_i = 0; end
      if (cnt == 7) begin start_i = 0; sel_evt_i = 0; src_pin_i = 1; end
      if (!busy_o) break;
    end
    chk(cnt == expc, inject == 1 ? "R10 R5 internal duration" :
        inject == 2 ? "R9 R5 internal duration" : "R5 internal duration", cnt, expc);
    chk(exp_q.size() == 0, "R6 all strobes issued", exp_q.size(), 0);
  endtask

  task automatic run_ext(input int n, input logic pg, input logic [AW-1:0] a, input logic [7:0] seed);
    int p, expp;
    expp = (pg ? n + 1 : 2 * n) * 128 + 1;
    launch(n, pg, a, seed);
    p = 0;
    while (p < 3000) begin
      ext_clk_i = 1; repeat (4) @(negedge clk);
      ext_clk_i = 0; repeat (4) @(negedge clk);
      p++;
      if (!busy_o) break;
    end
    chk(p == expp, pg ? "R4 external page duration" : "R3 external byte duration", p, expp);
    chk(exp_q.size() == 0, "R6 all strobes issued", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy_o && !erase_o && !wr_stb_o, "R1 reset state", {busy_o, erase_o, wr_stb_o}, 0);

    select_src(1'b1);
    chk(!ext_mode_o, "R9 internal selected", ext_mode_o, 0);
    run_int(3, 1'b0, 10'h2FE, 8'hA5, 0);   // R7 wrap 2FF->200
    run_int(8, 1'b1, 10'h15D, 8'h3C, 0);   // R8 wrap within page
    run_int(1, 1'b0, 10'h040, 8'h77, 1);   // R10
    run_int(2, 1'b0, 10'h0F0, 8'h12, 2);   // R9 selection while busy
    run_int(1, 1'b0, 10'h101, 8'h9E, 0);   // R9 mode kept afterwards

    select_src(1'b0);
    chk(ext_mode_o, "R9 external selected", ext_mode_o, 1);
    run_ext(1, 1'b0, 10'h020, 8'h5A);
    run_ext(7, 1'b0, 10'h3FC, 8'hC3);
    run_ext(8, 1'b1, 10'h0A8, 8'h81);
    run_ext(3, 1'b1, 10'h1FE, 8'h4D);

    // R11: reset in the middle of an external cycle
    launch(2, 1'b0, 10'h055, 8'h66);
    repeat (10) begin
      ext_clk_i = 1; repeat (4) @(negedge clk);
      ext_clk_i = 0; repeat (4) @(negedge clk);
    end
    rst = 1;
    @(negedge clk);
    chk(!busy_o, "R11 busy cleared by reset", busy_o, 0);
    rst = 0;
    exp_q.delete();
    @(negedge clk);
    chk(!ext_mode_o, "R11 mode back to internal", ext_mode_o, 0);
    repeat (50) @(negedge clk);
    run_int(1, 1'b0, 10'h300, 8'hE1, 0);   // R11 internal timing after reset

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule